// File: doc/BRIEF.md
# Register File with Direct-Mapped Virtual Word Cache

This block is one synchronous RAM that serves three kinds of client. The lowest region holds eight banks of sixteen accumulators. The middle region is scratch workspace for the control sequencer. The top region is a word cache indexed by the low virtual address bits. Every word is 36 data bits plus one odd-parity bit for each 18-bit half. A small side store keeps a tag and a valid flag for each cache line.

The sequencer issues at most one operation per clock. Accumulator and workspace operations read or write their own region. A storage lookup compares the stored tag with the page number of the request. On a hit it returns the cached word, so no storage bus cycle is needed. On a miss it reports that the bus must be used. When a storage read returns, or a storage write goes out, the sequencer issues a fill. The fill writes the word, its bus parity and the page tag into the line chosen by the in-page position. A reference from another page at the same position therefore evicts the old line, whether that reference is a read or a write.

Top module: `rf_cache_file`

## Requirements
- R1: After a synchronous active-high reset, the response outputs are zero and every cache line is invalid. A lookup that no fill has preceded since reset misses.
- R2: Accumulator operations are op code 1 (write) and op code 0 (read). The address is bank number times sixteen plus register number, and each location holds its own value independently.
- R3: Workspace operations are op code 3 (write) and op code 2 (read). An offset from 0 to 383 reaches its own location, and these writes leave accumulators and cache lines unchanged.
- R4: A workspace write with an offset of 384 or more has no effect on any location. A workspace read with such an offset returns data zero and no parity error.
- R5: A fill is op code 5. It stores the 36-bit data and the 2-bit bus parity (bit 0 covers data bits 17:0, bit 1 covers bits 35:18) in the line at index vaddr[8:0]. It records vaddr[17:9] as the tag and marks the line valid.
- R6: A lookup is op code 4. It hits when the line at vaddr[8:0] is valid and its tag equals vaddr[17:9]. It then returns rsp_hit=1 with the stored word.
- R7: A lookup that does not hit returns rsp_miss=1, data zero and no parity error. A fill from another page at the same index replaces the line, so the older page then misses.
- R8: Parity is odd: each half together with its parity bit holds an odd number of ones. Accumulator and workspace writes generate it. Any read that returns stored data raises rsp_perr when either half fails the check, and the data is still returned.
- R9: A read (op code 0, 2 or 4 with op_valid high) gives rsp_valid for exactly one cycle, two clocks after the operation is sampled. Writes, fills, op codes 6 and 7, and cycles with op_valid low give no response. With no response, data and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (see R2 to R6) |
| ac_blk | input | 3 | Accumulator bank number |
| ac_num | input | 4 | Register number within the bank |
| ws_off | input | 9 | Workspace offset |
| vaddr | input | 18 | Virtual address for lookup and fill |
| wdata | input | 36 | Write or fill data |
| wpar | input | 2 | Bus parity accompanying fill data |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 36 | Read data |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup miss |
| rsp_perr | output | 1 | Parity check failed on returned data |

## Verification
The bench builds the block with its default parameters: eight banks of sixteen, 384 workspace words, 512 cache lines and an 18-bit virtual address. At these sizes every region boundary is reachable. That includes offsets 384 and 511, which would land on cache lines 0 and 127 if the range guard failed. The nine-bit tag also lets two pages share one index, which exercises eviction. The bench also fills a line with parity broken in each half separately, so both halves of the parity check are exercised.

// File: rtl/rf_cache_pkg.sv
package rf_cache_pkg;
  localparam logic [2:0] OP_AC_RD   = 3'd0;
  localparam logic [2:0] OP_AC_WR   = 3'd1;
  localparam logic [2:0] OP_WS_RD   = 3'd2;
  localparam logic [2:0] OP_WS_WR   = 3'd3;
  localparam logic [2:0] OP_MEM_RD  = 3'd4;
  localparam logic [2:0] OP_MEM_FIL = 3'd5;

  // What the response stage does with the word read from the RAM
  typedef enum logic [1:0] {
    K_NONE  = 2'd0,
    K_RAM   = 2'd1,
    K_ZERO  = 2'd2,
    K_CACHE = 2'd3
  } rsp_kind_e;
endpackage

// File: rtl/rf_addr_map.sv
module rf_addr_map
  import rf_cache_pkg::*;
#(
  parameter int AC_BLOCKS   = 8,
  parameter int AC_REGS     = 16,
  parameter int WS_DEPTH    = 384,
  parameter int CACHE_DEPTH = 512,
  parameter int VADDR_W     = 18,
  localparam int AC_BW      = $clog2(AC_BLOCKS),
  localparam int AC_RW      = $clog2(AC_REGS),
  localparam int WS_OW      = $clog2(WS_DEPTH),
  localparam int IDX_W      = $clog2(CACHE_DEPTH),
  localparam int TAG_W      = VADDR_W - IDX_W,
  localparam int RAM_DEPTH  = AC_BLOCKS * AC_REGS + WS_DEPTH + CACHE_DEPTH,
  localparam int RAM_AW     = $clog2(RAM_DEPTH)
) (
  input  logic               op_valid,
  input  logic [2:0]         op_code,
  input  logic [AC_BW-1:0]   ac_blk,
  input  logic [AC_RW-1:0]   ac_num,
  input  logic [WS_OW-1:0]   ws_off,
  input  logic [VADDR_W-1:0] vaddr,
  output logic [RAM_AW-1:0]  ram_addr,
  output logic               ram_we,
  output logic               fill_sel,
  output logic               rd_op,
  output rsp_kind_e          kind,
  output logic [IDX_W-1:0]   cidx,
  output logic [TAG_W-1:0]   ctag,
  output logic               tag_we
);
  localparam int AC_TOTAL = AC_BLOCKS * AC_REGS;
  localparam int WS_BASE  = AC_TOTAL;
  localparam int C_BASE   = AC_TOTAL + WS_DEPTH;

  logic              ws_ok;
  logic [RAM_AW-1:0] ac_addr, ws_addr, c_addr;

  assign cidx    = vaddr[IDX_W-1:0];
  assign ctag    = vaddr[VADDR_W-1:IDX_W];
  assign ws_ok   = int'(ws_off) < WS_DEPTH;
  assign ac_addr = RAM_AW'({ac_blk, ac_num});
  assign ws_addr = RAM_AW'(WS_BASE) + RAM_AW'(ws_off);
  assign c_addr  = RAM_AW'(C_BASE) + RAM_AW'(cidx);

  always_comb begin
    ram_addr = ac_addr;
    ram_we   = 1'b0;
    fill_sel = 1'b0;
    rd_op    = 1'b0;
    kind     = K_NONE;
    tag_we   = 1'b0;
    if (op_valid) begin
      unique case (op_code)
        OP_AC_RD: begin
          rd_op = 1'b1;
          kind  = K_RAM;
        end
        OP_AC_WR: ram_we = 1'b1;
        OP_WS_RD: begin
          ram_addr = ws_addr;
          rd_op    = 1'b1;
          kind     = ws_ok ? K_RAM : K_ZERO;
        end
        OP_WS_WR: begin
          ram_addr = ws_addr;
          ram_we   = ws_ok;
        end
        OP_MEM_RD: begin
          ram_addr = c_addr;
          rd_op    = 1'b1;
          kind     = K_CACHE;
        end
        OP_MEM_FIL: begin
          ram_addr = c_addr;
          ram_we   = 1'b1;
          fill_sel = 1'b1;
          tag_we   = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rf_ram.sv
module rf_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 38,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single port, read-first, no reset: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/rf_tag_store.sv
module rf_tag_store #(
  parameter int DEPTH = 512,
  parameter int TAG_W = 9,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IW-1:0]    idx,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_q,
  output logic             vld_q
);
  logic [TAG_W-1:0] tags [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) tags[idx] <= tag_in;
    tag_q <= tags[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_q <= 1'b0;
    end else begin
      if (we) vld[idx] <= 1'b1;
      vld_q <= vld[idx];
    end
  end
endmodule

// File: rtl/rf_rsp_stage.sv
module rf_rsp_stage
  import rf_cache_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int TAG_W  = 9,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  rsp_kind_e         s1_kind,
  input  logic [TAG_W-1:0]  s1_tag,
  input  logic [DATA_W+1:0] word_q,
  input  logic [TAG_W-1:0]  tag_q,
  input  logic              vld_q,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_perr
);
  logic hit, miss, use_word, lo_bad, hi_bad;

  assign hit      = (s1_kind == K_CACHE) && vld_q && (tag_q == s1_tag);
  assign miss     = (s1_kind == K_CACHE) && !hit;
  assign use_word = (s1_kind == K_RAM) || hit;
  assign lo_bad   = ~^{word_q[DATA_W], word_q[HALF-1:0]};
  assign hi_bad   = ~^{word_q[DATA_W+1], word_q[DATA_W-1:HALF]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_perr  <= 1'b0;
    end else begin
      rsp_valid <= s1_valid;
      rsp_data  <= (s1_valid && use_word) ? word_q[DATA_W-1:0] : '0;
      rsp_hit   <= s1_valid && hit;
      rsp_miss  <= s1_valid && miss;
      rsp_perr  <= s1_valid && use_word && (lo_bad || hi_bad);
    end
  end
endmodule

// File: rtl/rf_cache_file.sv
module rf_cache_file
  import rf_cache_pkg::*;
#(
  parameter int DATA_W      = 36,
  parameter int AC_BLOCKS   = 8,
  parameter int AC_REGS     = 16,
  parameter int WS_DEPTH    = 384,
  parameter int CACHE_DEPTH = 512,
  parameter int VADDR_W     = 18,
  localparam int AC_BW      = $clog2(AC_BLOCKS),
  localparam int AC_RW      = $clog2(AC_REGS),
  localparam int WS_OW      = $clog2(WS_DEPTH),
  localparam int IDX_W      = $clog2(CACHE_DEPTH),
  localparam int TAG_W      = VADDR_W - IDX_W,
  localparam int HALF       = DATA_W / 2,
  localparam int WORD_W     = DATA_W + 2,
  localparam int RAM_DEPTH  = AC_BLOCKS * AC_REGS + WS_DEPTH + CACHE_DEPTH,
  localparam int RAM_AW     = $clog2(RAM_DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [2:0]         op_code,
  input  logic [AC_BW-1:0]   ac_blk,
  input  logic [AC_RW-1:0]   ac_num,
  input  logic [WS_OW-1:0]   ws_off,
  input  logic [VADDR_W-1:0] vaddr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [1:0]         wpar,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_hit,
  output logic               rsp_miss,
  output logic               rsp_perr
);
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we, fill_sel, rd_op, tag_we;
  rsp_kind_e         kind;
  logic [IDX_W-1:0]  cidx;
  logic [TAG_W-1:0]  ctag;
  logic [1:0]        gen_par, wr_par;
  logic [WORD_W-1:0] ram_wdata, word_q;
  logic [TAG_W-1:0]  tag_q;
  logic              vld_q;

  logic              s1_valid;
  rsp_kind_e         s1_kind;
  logic [TAG_W-1:0]  s1_tag;

  rf_addr_map #(
    .AC_BLOCKS(AC_BLOCKS), .AC_REGS(AC_REGS), .WS_DEPTH(WS_DEPTH),
    .CACHE_DEPTH(CACHE_DEPTH), .VADDR_W(VADDR_W)
  ) u_map (
    .op_valid(op_valid), .op_code(op_code), .ac_blk(ac_blk), .ac_num(ac_num),
    .ws_off(ws_off), .vaddr(vaddr), .ram_addr(ram_addr), .ram_we(ram_we),
    .fill_sel(fill_sel), .rd_op(rd_op), .kind(kind), .cidx(cidx),
    .ctag(ctag), .tag_we(tag_we)
  );

  // odd parity per half word for locally generated writes
  assign gen_par   = {~^wdata[DATA_W-1:HALF], ~^wdata[HALF-1:0]};
  assign wr_par    = fill_sel ? wpar : gen_par;
  assign ram_wdata = {wr_par, wdata};

  rf_ram #(.DEPTH(RAM_DEPTH), .WIDTH(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(word_q)
  );

  rf_tag_store #(.DEPTH(CACHE_DEPTH), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .we(tag_we), .idx(cidx), .tag_in(ctag),
    .tag_q(tag_q), .vld_q(vld_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= K_NONE;
      s1_tag   <= '0;
    end else begin
      s1_valid <= rd_op;
      s1_kind  <= kind;
      s1_tag   <= ctag;
    end
  end

  rf_rsp_stage #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rsp (
    .clk(clk), .rst(rst), .s1_valid(s1_valid), .s1_kind(s1_kind),
    .s1_tag(s1_tag), .word_q(word_q), .tag_q(tag_q), .vld_q(vld_q),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_perr(rsp_perr)
  );
endmodule

// File: rtl/rf_cache_file_chk.sv
module rf_cache_file_chk
  import rf_cache_pkg::*;
#(
  parameter int DATA_W   = 36,
  parameter int WS_DEPTH = 384,
  parameter int WS_OW    = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid,
  input logic [2:0]        op_code,
  input logic [WS_OW-1:0]  ws_off,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic              rsp_perr
);
  logic rd0, oob0, lk0;
  logic rd1, rd2, oob1, oob2, lk1, lk2, nf1, nf2, fill_seen;

  assign rd0  = op_valid && (op_code == OP_AC_RD || op_code == OP_WS_RD ||
                             op_code == OP_MEM_RD);
  assign oob0 = op_valid && op_code == OP_WS_RD && int'(ws_off) >= WS_DEPTH;
  assign lk0  = op_valid && op_code == OP_MEM_RD;

  always_ff @(posedge clk) begin
    if (rst) begin
      {rd1, rd2, oob1, oob2, lk1, lk2, nf1, nf2, fill_seen} <= '0;
    end else begin
      rd1 <= rd0;   rd2 <= rd1;
      oob1 <= oob0; oob2 <= oob1;
      lk1 <= lk0;   lk2 <= lk1;
      nf1 <= lk0 && !fill_seen; nf2 <= nf1;
      if (op_valid && op_code == OP_MEM_FIL) fill_seen <= 1'b1;
    end
  end

  p_rsp_timing_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == rd2);
  p_quiet_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_perr && rsp_data == '0));
  p_no_early_hit_r1: assert property (@(posedge clk) disable iff (rst)
    nf2 |-> !rsp_hit);
  p_hit_xor_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && lk2) |-> (rsp_hit != rsp_miss));
  p_flags_only_lookup_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !lk2) |-> (!rsp_hit && !rsp_miss));
  p_miss_blank_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_data == '0 && !rsp_perr));
  p_ws_range_zero_r4: assert property (@(posedge clk) disable iff (rst)
    oob2 |-> (rsp_data == '0 && !rsp_perr));
endmodule

bind rf_cache_file rf_cache_file_chk #(
  .DATA_W(DATA_W), .WS_DEPTH(WS_DEPTH), .WS_OW(WS_OW)
) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .ws_off(ws_off), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_perr(rsp_perr)
);

// File: tb/rf_cache_file_tb_top.sv
module rf_cache_file_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic [2:0]  ac_blk = '0;
  logic [3:0]  ac_num = '0;
  logic [8:0]  ws_off = '0;
  logic [17:0] vaddr = '0;
  logic [35:0] wdata = '0;
  logic [1:0]  wpar = '0;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_perr;
  logic [35:0] rsp_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rf_cache_file dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .ac_blk(ac_blk), .ac_num(ac_num), .ws_off(ws_off), .vaddr(vaddr),
    .wdata(wdata), .wpar(wpar), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_perr(rsp_perr)
  );

  // ---------------- behavioural reference model ----------------
  logic [37:0] ac_m [128];
  logic [37:0] ws_m [384];
  logic [37:0] c_m  [512];
  int          ct_m [512];
  bit          cv_m [512];

  // expected response pipe: [0] newest, [1] due at the outputs now
  bit          e_v [2];
  logic [35:0] e_d [2];
  bit          e_h [2], e_m [2], e_p [2];
  int          e_r [2];

  function automatic logic [1:0] odd_par(input logic [35:0] d);
    return {~^d[35:18], ~^d[17:0]};
  endfunction

  function automatic bit par_bad(input logic [37:0] w);
    return ((^{w[36], w[17:0]}) != 1'b1) || ((^{w[37], w[35:18]}) != 1'b1);
  endfunction

  always @(posedge clk) begin
    bit          nv, nh, nm, np;
    logic [35:0] nd;
    int          nr, idx, tg;
    nv = 0; nh = 0; nm = 0; np = 0; nd = '0; nr = 9;
    idx = int'(vaddr[8:0]); tg = int'(vaddr[17:9]);
    if (rst) begin
      foreach (cv_m[i]) cv_m[i] = 0;
      e_v[0] = 0; e_v[1] = 0; e_h[1] = 0; e_m[1] = 0; e_p[1] = 0;
      e_d[1] = '0; e_r[1] = 1;
    end else begin
      if (op_valid) begin
        case (op_code)
          3'd0: begin nv = 1; nr = 2; nd = ac_m[{ac_blk, ac_num}][35:0];
                      np = par_bad(ac_m[{ac_blk, ac_num}]); end
          3'd1: ac_m[{ac_blk, ac_num}] = {odd_par(wdata), wdata};
          3'd2: begin
            nv = 1;
            if (ws_off < 384) begin nr = 3; nd = ws_m[ws_off][35:0]; np = par_bad(ws_m[ws_off]); end
            else nr = 4;
          end
          3'd3: if (ws_off < 384) ws_m[ws_off] = {odd_par(wdata), wdata};
          3'd4: begin
            nv = 1;
            if (cv_m[idx] && ct_m[idx] == tg) begin
              nh = 1; nd = c_m[idx][35:0]; np = par_bad(c_m[idx]); nr = np ? 8 : 6;
            end else begin nm = 1; nr = 7; end
          end
          3'd5: begin c_m[idx] = {wpar, wdata}; ct_m[idx] = tg; cv_m[idx] = 1; end
          default: ;
        endcase
      end
      e_v[1] = e_v[0]; e_d[1] = e_d[0]; e_h[1] = e_h[0];
      e_m[1] = e_m[0]; e_p[1] = e_p[0]; e_r[1] = e_r[0];
      e_v[0] = nv; e_d[0] = nd; e_h[0] = nh; e_m[0] = nm; e_p[0] = np; e_r[0] = nr;
    end
  end

  // compare on every falling edge, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if (rsp_valid !== e_v[1] || rsp_data !== e_d[1] || rsp_hit !== e_h[1] ||
          rsp_miss !== e_m[1] || rsp_perr !== e_p[1]) begin
        n_errors++;
        $display("FAIL R%0d: got v=%0b d=%h h=%0b m=%0b p=%0b exp v=%0b d=%h h=%0b m=%0b p=%0b",
                 e_r[1], rsp_valid, rsp_data, rsp_hit, rsp_miss, rsp_perr,
                 e_v[1], e_d[1], e_h[1], e_m[1], e_p[1]);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input logic [2:0] c, input logic [2:0] b, input logic [3:0] r,
                     input logic [8:0] o, input logic [17:0] va,
                     input logic [35:0] d, input logic [1:0] p);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; ac_blk = b; ac_num = r; ws_off = o;
    vaddr = va; wdata = d; wpar = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  task automatic fill(input logic [17:0] va, input logic [35:0] d, input logic [1:0] flip);
    put(3'd5, 3'd0, 4'd0, 9'd0, va, d, odd_par(d) ^ flip);
  endtask

  task automatic look(input logic [17:0] va);
    put(3'd4, 3'd0, 4'd0, 9'd0, va, '0, 2'b00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs zero straight after reset
    n_checks++;
    if (rsp_valid !== 1'b0 || rsp_data !== '0 || rsp_hit !== 1'b0 ||
        rsp_miss !== 1'b0 || rsp_perr !== 1'b0) begin
      n_errors++;
      $display("FAIL R1: outputs not zero in reset, got v=%0b d=%h exp all zero", rsp_valid, rsp_data);
    end
    rst = 1'b0;
    idle(2);
    // R1 / R7: nothing valid yet, every lookup misses
    look(18'h00000); look(18'h3FFFF); look(18'h00155);
    // R2: every bank, registers at both ends and the middle
    for (int b = 0; b < 8; b++)
      for (int r = 0; r < 16; r += 7)
        put(3'd1, 3'(b), 4'(r), 9'd0, '0, {4'(b), 4'(r), 28'h5A5A0C3} ^ {36{b[0]}}, 2'b00);
    put(3'd1, 3'd7, 4'd15, 9'd0, '0, 36'hF_0F0F_0F0F, 2'b00);
    for (int b = 0; b < 8; b++)
      for (int r = 0; r < 16; r += 7)
        put(3'd0, 3'(b), 4'(r), 9'd0, '0, '0, 2'b00);
    put(3'd0, 3'd7, 4'd15, 9'd0, '0, '0, 2'b00);
    // R9: back-to-back write then read of one register
    put(3'd1, 3'd3, 4'd4, 9'd0, '0, 36'h1_2345_6789, 2'b00);
    put(3'd0, 3'd3, 4'd4, 9'd0, '0, '0, 2'b00);
    // R3: workspace edges, then accumulators untouched
    put(3'd3, 3'd0, 4'd0, 9'd0,   '0, 36'hA_AAAA_AAAA, 2'b00);
    put(3'd3, 3'd0, 4'd0, 9'd1,   '0, 36'h0_0000_0001, 2'b00);
    put(3'd3, 3'd0, 4'd0, 9'd200, '0, 36'h7_FFFF_FFFF, 2'b00);
    put(3'd3, 3'd0, 4'd0, 9'd383, '0, 36'h8_0000_0000, 2'b00);
    put(3'd2, 3'd0, 4'd0, 9'd0,   '0, '0, 2'b00);
    put(3'd2, 3'd0, 4'd0, 9'd1,   '0, '0, 2'b00);
    put(3'd2, 3'd0, 4'd0, 9'd200, '0, '0, 2'b00);
    put(3'd2, 3'd0, 4'd0, 9'd383, '0, '0, 2'b00);
    put(3'd0, 3'd0, 4'd0, 9'd0, '0, '0, 2'b00);
    put(3'd0, 3'd7, 4'd15, 9'd0, '0, '0, 2'b00);
    // R4 / R5: out-of-range workspace writes must not reach cache lines 0 and 127
    fill(18'h00000, 36'hC_0FFE_E000, 2'b00);
    fill(18'h0007F, 36'h3_1415_9265, 2'b00);
    fill(18'h3FFFF, 36'hB_EEF0_1234, 2'b00);
    put(3'd3, 3'd0, 4'd0, 9'd384, '0, 36'hD_EAD0_DEAD, 2'b00);
    put(3'd3, 3'd0, 4'd0, 9'd511, '0, 36'hD_EAD0_BEEF, 2'b00);
    put(3'd2, 3'd0, 4'd0, 9'd384, '0, '0, 2'b00);
    put(3'd2, 3'd0, 4'd0, 9'd511, '0, '0, 2'b00);
    look(18'h00000); look(18'h0007F); look(18'h3FFFF);
    // R6 / R7: two pages sharing index 5
    fill(18'h00205, 36'h0_1111_2222, 2'b00);
    look(18'h00205);
    look(18'h00405);
    fill(18'h00405, 36'h0_3333_4444, 2'b00);
    look(18'h00205);
    look(18'h00405);
    // R8: bad parity in the low half, then the high half, then good
    fill(18'h00010, 36'h0_00FF_00FF, 2'b01);
    fill(18'h00011, 36'h0_00FF_00FF, 2'b10);
    fill(18'h00012, 36'h0_00FF_00FF, 2'b00);
    look(18'h00010); look(18'h00011); look(18'h00012);
    // R9: unused codes and read codes with op_valid low give nothing
    put(3'd6, 3'd0, 4'd0, 9'd0, 18'h00010, '0, 2'b00);
    put(3'd7, 3'd0, 4'd0, 9'd0, 18'h00010, '0, 2'b00);
    @(negedge clk); op_valid = 1'b0; op_code = 3'd4; vaddr = 18'h00205;
    @(negedge clk); op_code = 3'd0;
    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL R9: watchdog expired, got no end of test, exp finish");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule